// File: doc/BRIEF.md
# Structure De-interleaving Packer

This block sits between a memory byte stream and a vector register file. It handles loads and stores of arrays of small structures, where each structure has one to four members. On a load, bytes arrive one per handshake beat. Member `s` of structure `e` lands in lane `e` of destination register `base + s`, and the register number wraps at 32. Each destination register is sent out on the write port once, as a full-width value, in the cycle after its final lane is filled.

On a store the same walk runs the other way. The block reads lanes out of the source registers and emits them as a byte stream in memory order.

A command is given by a `start` pulse with these settings:
- the element size, as a 2-bit code;
- the register width, 64 or 128 bits;
- the member count minus one;
- the first register number.

At the same pulse the block captures the current contents of the member registers from `reg_in`. For a load these are the values that unwritten lanes keep; for a store they are the data to send. A `done` pulse closes the command. A forbidden setting raises `err` instead.

Top module: `struct_deinterleave`

## Requirements
- R1: `cfg_size` selects the element width as 8 << cfg_size bits (code 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). `cfg_wide` = 1 selects a 128-bit register and 0 selects a 64-bit register. Each register holds (register bytes / element bytes) lanes.
- R2: Stream order is structure-major. For structure e = 0 up to lanes-1, members s = 0 up to cfg_members_m1 follow in turn, and each element occupies element-bytes consecutive stream bytes.
- R3: Member s is written to register index (cfg_base + s) mod 32.
- R4: Within a lane, the first stream byte of the element is the least significant byte (little-endian). Lane e starts at bit e * element width.
- R5: On a load, bits of a destination register not covered by a lane (the upper 64 bits when `cfg_wide` = 0) keep the value captured from `reg_in` slice s (bits s*128 and up) at start.
- R6: On a load, each member register is written exactly once, one cycle after the handshake that fills its last lane. Writes come in the order base, base+1, and so on.
- R7: cfg_size = 3 with cfg_wide = 0 and more than one member is forbidden. The block then pulses `err` for one cycle, in the cycle after `start`, stays idle, and neither writes nor raises `done`. With one member, the same size and width is legal.
- R8: On a store, `out_data` presents the bytes of `reg_in` in the R2 order, taking each byte from the R4 position.
- R9: `in_ready` is high only while a load is in progress, and `out_valid` is high only while a store is in progress. While `out_ready` is low, `out_data` holds.
- R10: `done` pulses for one cycle, one cycle after the final byte handshake, and `busy` is low in that cycle. For a load, `done` coincides with the last register write.
- R11: A `start` that arrives while `busy` is high is ignored, and changes to the configuration inputs during a command have no effect on that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cfg_store | input | 1 | 1 = store (interleave), 0 = load (de-interleave) |
| cfg_size | input | 2 | Element size code |
| cfg_wide | input | 1 | 1 = 128-bit registers, 0 = 64-bit |
| cfg_members_m1 | input | 2 | Structure members minus one |
| cfg_base | input | 5 | First register number |
| reg_in | input | 512 | Current contents of the member registers, slice s = member s |
| in_valid | input | 1 | Load byte valid |
| in_data | input | 8 | Load byte |
| in_ready | output | 1 | Load byte accepted |
| out_valid | output | 1 | Store byte valid |
| out_data | output | 8 | Store byte |
| out_ready | input | 1 | Store byte taken |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register number being written |
| wr_data | output | 128 | Full register value being written |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Forbidden configuration pulse |

## Verification
The bench builds the block with its default parameters: 128-bit registers, up to four members and a 5-bit register index. With these values every element size can be reached in both register widths, and so can the wrap of register numbers past 31. Loads run with three members at byte granularity, with three members at 16-bit size starting at register 30, and with four members at 64-bit size. The narrow loads show the preserved upper halves. Stall gaps on the input and backpressure on the output exercise the handshake. A mid-command `start` with altered settings shows that the latched configuration holds.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [1:0] {
    SDL_IDLE  = 2'd0,
    SDL_LOAD  = 2'd1,
    SDL_STORE = 2'd2
  } sdl_state_e;

  typedef struct packed {
    logic [1:0] size;
    logic       wide;
  } sdl_shape_t;
endpackage

// File: rtl/sdl_cfg_decode.sv
module sdl_cfg_decode #(
  parameter int REG_W = 128,
  parameter int MB_W  = 2,
  localparam int CW   = $clog2(REG_W / 8) + 1
) (
  input  logic [1:0]      size,
  input  logic            wide,
  input  logic [MB_W-1:0] nm1,
  output logic [CW-1:0]   ebytes,
  output logic [CW-1:0]   rbytes,
  output logic            illegal
);
  assign ebytes = CW'(1) << size;
  assign rbytes = wide ? CW'(16) : CW'(8);

  generate
    if (REG_W >= 128) begin : g_full
      assign illegal = (size == 2'b11) && !wide && (nm1 != '0);
    end else begin : g_narrow
      assign illegal = wide || ((size == 2'b11) && (nm1 != '0));
    end
  endgenerate
endmodule

// File: rtl/sdl_walker.sv
module sdl_walker #(
  parameter int REG_W = 128,
  parameter int MB_W  = 2,
  localparam int PW   = $clog2(REG_W / 8),
  localparam int CW   = PW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            step,
  input  logic [CW-1:0]   ebytes,
  input  logic [CW-1:0]   rbytes,
  input  logic [MB_W-1:0] nm1,
  output logic [PW-1:0]   pos,
  output logic [MB_W-1:0] memb,
  output logic            lane_last,
  output logic            finish
);
  logic [PW-1:0] bcnt;
  logic [PW-1:0] ebase;
  logic          elem_end;
  logic          memb_end;

  assign elem_end  = ({1'b0, bcnt} == (ebytes - CW'(1)));
  assign memb_end  = (memb == nm1);
  assign lane_last = elem_end && (({1'b0, ebase} + ebytes) == rbytes);
  assign finish    = lane_last && memb_end;
  assign pos       = ebase + bcnt;

  always_ff @(posedge clk) begin
    if (rst || go) begin
      bcnt  <= '0;
      ebase <= '0;
      memb  <= '0;
    end else if (step) begin
      if (elem_end) begin
        bcnt <= '0;
        if (memb_end) begin
          memb  <= '0;
          ebase <= ebase + ebytes[PW-1:0];
        end else begin
          memb <= memb + MB_W'(1);
        end
      end else begin
        bcnt <= bcnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/sdl_lane_bank.sv
module sdl_lane_bank #(
  parameter int REG_W = 128,
  parameter int MEMB  = 4,
  localparam int MB_W = $clog2(MEMB),
  localparam int PW   = $clog2(REG_W / 8)
) (
  input  logic                  clk,
  input  logic                  go,
  input  logic [MEMB*REG_W-1:0] init,
  input  logic                  wr,
  input  logic [MB_W-1:0]       memb,
  input  logic [PW-1:0]         pos,
  input  logic [7:0]            byte_in,
  output logic [REG_W-1:0]      merged,
  output logic [7:0]            rd_byte
);
  logic [REG_W-1:0] bank [MEMB];

  always_ff @(posedge clk) begin
    if (go) begin
      for (int m = 0; m < MEMB; m++) bank[m] <= init[m*REG_W +: REG_W];
    end else if (wr) begin
      bank[memb][{pos, 3'b000} +: 8] <= byte_in;
    end
  end

  always_comb begin
    merged = bank[memb];
    merged[{pos, 3'b000} +: 8] = byte_in;
  end

  assign rd_byte = bank[memb][{pos, 3'b000} +: 8];
endmodule

// File: rtl/struct_deinterleave.sv
module struct_deinterleave #(
  parameter int REG_W = 128,
  parameter int MEMB  = 4,
  parameter int IDX_W = 5,
  localparam int MB_W = $clog2(MEMB),
  localparam int PW   = $clog2(REG_W / 8),
  localparam int CW   = PW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  cfg_store,
  input  logic [1:0]            cfg_size,
  input  logic                  cfg_wide,
  input  logic [MB_W-1:0]       cfg_members_m1,
  input  logic [IDX_W-1:0]      cfg_base,
  input  logic [MEMB*REG_W-1:0] reg_in,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  in_ready,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  input  logic                  out_ready,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [REG_W-1:0]      wr_data,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);
  import sdl_pkg::*;

  sdl_state_e       state;
  sdl_shape_t       lat_shape;
  sdl_shape_t       cur_shape;
  logic [MB_W-1:0]  lat_nm1;
  logic [MB_W-1:0]  cur_nm1;
  logic [IDX_W-1:0] lat_base;
  logic [CW-1:0]    ebytes;
  logic [CW-1:0]    rbytes;
  logic             illegal;
  logic             idle;
  logic             go;
  logic             step;
  logic [PW-1:0]    pos;
  logic [MB_W-1:0]  memb;
  logic             lane_last;
  logic             finish;
  logic [REG_W-1:0] merged;
  logic [7:0]       rd_byte;

  assign idle      = (state == SDL_IDLE);
  assign cur_shape = idle ? '{size: cfg_size, wide: cfg_wide} : lat_shape;
  assign cur_nm1   = idle ? cfg_members_m1 : lat_nm1;
  assign go        = idle && start && !illegal;
  assign step      = ((state == SDL_LOAD) && in_valid) ||
                     ((state == SDL_STORE) && out_ready);

  sdl_cfg_decode #(.REG_W(REG_W), .MB_W(MB_W)) u_dec (
    .size    (cur_shape.size),
    .wide    (cur_shape.wide),
    .nm1     (cur_nm1),
    .ebytes  (ebytes),
    .rbytes  (rbytes),
    .illegal (illegal)
  );

  sdl_walker #(.REG_W(REG_W), .MB_W(MB_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .step      (step),
    .ebytes    (ebytes),
    .rbytes    (rbytes),
    .nm1       (cur_nm1),
    .pos       (pos),
    .memb      (memb),
    .lane_last (lane_last),
    .finish    (finish)
  );

  sdl_lane_bank #(.REG_W(REG_W), .MEMB(MEMB)) u_bank (
    .clk     (clk),
    .go      (go),
    .init    (reg_in),
    .wr      ((state == SDL_LOAD) && in_valid),
    .memb    (memb),
    .pos     (pos),
    .byte_in (in_data),
    .merged  (merged),
    .rd_byte (rd_byte)
  );

  assign in_ready  = (state == SDL_LOAD);
  assign out_valid = (state == SDL_STORE);
  assign out_data  = rd_byte;
  assign busy      = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SDL_IDLE;
      lat_shape <= '0;
      lat_nm1   <= '0;
      lat_base  <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      unique case (state)
        SDL_IDLE: begin
          if (start) begin
            if (illegal) begin
              err <= 1'b1;
            end else begin
              lat_shape <= cur_shape;
              lat_nm1   <= cfg_members_m1;
              lat_base  <= cfg_base;
              state     <= cfg_store ? SDL_STORE : SDL_LOAD;
            end
          end
        end
        SDL_LOAD: begin
          if (step) begin
            if (lane_last) begin
              wr_en   <= 1'b1;
              wr_idx  <= lat_base + IDX_W'(memb);
              wr_data <= merged;
            end
            if (finish) begin
              done  <= 1'b1;
              state <= SDL_IDLE;
            end
          end
        end
        SDL_STORE: begin
          if (step && finish) begin
            done  <= 1'b1;
            state <= SDL_IDLE;
          end
        end
        default: state <= SDL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       wr_en,
  input logic       busy,
  input logic       done,
  input logic       err
);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (!wr_en && !busy && !done));

  a_r9_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (busy && !out_valid));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_write_after_beat: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_valid && in_ready));

  a_r10_done_after_beat: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past((in_valid && in_ready) || (out_valid && out_ready)) && !busy));
endmodule

bind struct_deinterleave sdl_checker i_sdl_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .wr_en     (wr_en),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/test_struct_deinterleave.sv
module test_struct_deinterleave;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cfg_store = 1'b0;
  logic [1:0]   cfg_size = '0;
  logic         cfg_wide = 1'b0;
  logic [1:0]   cfg_members_m1 = '0;
  logic [4:0]   cfg_base = '0;
  logic [511:0] reg_in = '0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic [7:0]   out_data;
  logic         out_ready = 1'b0;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic [127:0] wr_data;
  logic         busy;
  logic         done;
  logic         err;

  int n_checks = 0;
  int n_errors = 0;

  logic [4:0]   mon_idx  [8];
  logic [127:0] mon_data [8];
  int           mon_cnt = 0;
  int           done_cnt = 0;
  int           err_cnt = 0;
  logic         done_with_wr = 1'b0;

  always #4 clk = ~clk;

  struct_deinterleave i_struct_deinterleave (
    .clk(clk), .rst(rst), .start(start), .cfg_store(cfg_store),
    .cfg_size(cfg_size), .cfg_wide(cfg_wide), .cfg_members_m1(cfg_members_m1),
    .cfg_base(cfg_base), .reg_in(reg_in), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (mon_cnt < 8) begin
          mon_idx[mon_cnt]  = wr_idx;
          mon_data[mon_cnt] = wr_data;
        end
        mon_cnt++;
      end
      if (done) begin
        done_cnt++;
        done_with_wr = wr_en;
      end
      if (err) err_cnt++;
    end
  end

  task automatic check(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic logic [7:0] prior_byte(input int s, input int j);
    return 8'(8'hC0 + s * 16 + j);
  endfunction

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'(k * 37 + seed);
  endfunction

  task automatic fill_prior();
    for (int s = 0; s < 4; s++)
      for (int j = 0; j < 16; j++)
        reg_in[s*128 + j*8 +: 8] = prior_byte(s, j);
  endtask

  task automatic issue(input bit st, input logic [1:0] sz, input bit wide,
                       input logic [1:0] nm1, input logic [4:0] base);
    @(negedge clk);
    mon_cnt = 0; done_cnt = 0; err_cnt = 0; done_with_wr = 1'b0;
    cfg_store = st; cfg_size = sz; cfg_wide = wide;
    cfg_members_m1 = nm1; cfg_base = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_load(input logic [1:0] sz, input bit wide, input logic [1:0] nm1,
                          input logic [4:0] base, input bit stall, input bit intrude,
                          input int seed, input string tag);
    int eb, rb, lanes, nmem, k, cyc;
    bit acc;
    logic [127:0] expr [4];
    eb = 1 << sz; rb = wide ? 16 : 8; lanes = rb / eb; nmem = int'(nm1) + 1;
    fill_prior();
    for (int s = 0; s < 4; s++) expr[s] = reg_in[s*128 +: 128];
    k = 0;
    for (int e = 0; e < lanes; e++)
      for (int s = 0; s < nmem; s++)
        for (int b = 0; b < eb; b++) begin
          expr[s][(e*eb + b)*8 +: 8] = pat(k, seed);
          k++;
        end
    issue(1'b0, sz, wide, nm1, base);
    check(busy === 1'b1 && in_ready === 1'b1 && out_valid === 1'b0,
          {tag, " R9 load handshake"}, {in_ready, out_valid}, 2'b10);
    cyc = 0;
    for (int kk = 0; kk < lanes * eb * nmem; kk++) begin
      acc = 1'b0;
      while (!acc) begin
        if (cyc > 0) @(negedge clk);
        start = 1'b0;
        if (intrude && kk == 5) begin
          start = 1'b1; cfg_store = 1'b1; cfg_size = 2'd3; cfg_base = 5'd9;
          cfg_members_m1 = 2'd0; cfg_wide = ~wide;
        end
        if (stall && (cyc % 4 == 3)) begin
          in_valid = 1'b0;
        end else begin
          in_valid = 1'b1;
          in_data  = pat(kk, seed);
        end
        cyc++;
        acc = in_valid && in_ready;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; start = 1'b0;
    #1;
    check(mon_cnt == nmem, {tag, " R6 write count"}, 128'(mon_cnt), 128'(nmem));
    for (int i = 0; i < nmem && i < 8; i++) begin
      check(mon_idx[i] == 5'(int'(base) + i), {tag, " R3 register index"},
            128'(mon_idx[i]), 128'(5'(int'(base) + i)));
      check(mon_data[i] == expr[i], {tag, " R2/R4/R5 register value"},
            mon_data[i], expr[i]);
    end
    check(done_cnt == 1 && done_with_wr === 1'b1, {tag, " R10 done with last write"},
          128'(done_cnt), 128'(1));
    check(busy === 1'b0, {tag, " R10 idle after done"}, 128'(busy), 128'(0));
  endtask

  task automatic run_store(input logic [1:0] sz, input bit wide, input logic [1:0] nm1,
                           input bit bp, input string tag);
    int eb, rb, lanes, nmem, cyc, mism, got;
    bit acc;
    logic [7:0] firstbad_a, firstbad_e;
    eb = 1 << sz; rb = wide ? 16 : 8; lanes = rb / eb; nmem = int'(nm1) + 1;
    for (int s = 0; s < 4; s++)
      for (int j = 0; j < 16; j++)
        reg_in[s*128 + j*8 +: 8] = 8'(s * 59 + j * 13 + 5);
    issue(1'b1, sz, wide, nm1, 5'd0);
    check(out_valid === 1'b1 && in_ready === 1'b0, {tag, " R9 store handshake"},
          {in_ready, out_valid}, 2'b01);
    reg_in = '0;
    cyc = 0; mism = 0; got = 0; firstbad_a = '0; firstbad_e = '0;
    for (int e = 0; e < lanes; e++)
      for (int s = 0; s < nmem; s++)
        for (int b = 0; b < eb; b++) begin
          acc = 1'b0;
          while (!acc) begin
            if (cyc > 0) @(negedge clk);
            out_ready = !(bp && (cyc % 3 == 1));
            cyc++;
            if (out_ready && out_valid) begin
              acc = 1'b1;
              got++;
              if (out_data !== 8'(s * 59 + (e*eb + b) * 13 + 5)) begin
                if (mism == 0) begin
                  firstbad_a = out_data;
                  firstbad_e = 8'(s * 59 + (e*eb + b) * 13 + 5);
                end
                mism++;
              end
            end else if (!out_valid) begin
              acc = 1'b1;
              mism++;
            end
          end
        end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(mism == 0, {tag, " R8 store byte order"}, 128'(firstbad_a), 128'(firstbad_e));
    check(got == lanes * eb * nmem, {tag, " R8 store byte count"}, 128'(got),
          128'(lanes * eb * nmem));
    check(done_cnt == 1 && busy === 1'b0, {tag, " R10 store done"},
          128'(done_cnt), 128'(1));
    check(mon_cnt == 0, {tag, " R9 no writes on store"}, 128'(mon_cnt), 128'(0));
  endtask

  task automatic run_illegal();
    fill_prior();
    issue(1'b0, 2'd3, 1'b0, 2'd2, 5'd4);
    #1;
    check(err === 1'b1 && busy === 1'b0, "R7 err pulse after start",
          {err, busy}, 2'b10);
    @(negedge clk);
    #1;
    check(err === 1'b0, "R7 err is one cycle", 128'(err), 128'(0));
    check(in_ready === 1'b0 && out_valid === 1'b0, "R7 R9 stays idle",
          {in_ready, out_valid}, 2'b00);
    repeat (3) @(negedge clk);
    #1;
    check(mon_cnt == 0 && done_cnt == 0 && err_cnt == 1, "R7 no write or done",
          128'(mon_cnt + done_cnt), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "reset state idle",
          {busy, done, err}, 3'b000);
    check(wr_en === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0,
          "R9 reset handshake low", {wr_en, in_ready, out_valid}, 3'b000);
    // R1 R2 R4: byte lanes, three members, 128-bit, with input gaps
    run_load(2'd0, 1'b1, 2'd2, 5'd5, 1'b1, 1'b0, 11, "byte3x128");
    // R3 R5: wrap 30,31,0 and preserved upper halves
    run_load(2'd1, 1'b0, 2'd2, 5'd30, 1'b0, 1'b0, 3, "half3x64");
    // R1 R4: 64-bit elements, four members
    run_load(2'd3, 1'b1, 2'd3, 5'd12, 1'b1, 1'b0, 71, "dword4x128");
    // R7 boundary: single member with size code 3 in 64-bit registers is legal
    run_load(2'd3, 1'b0, 2'd0, 5'd31, 1'b0, 1'b0, 29, "single64");
    run_illegal();
    // R11: start with altered settings mid-command is ignored
    run_load(2'd2, 1'b1, 2'd2, 5'd20, 1'b0, 1'b1, 101, "R11 intrude");
    // R8 R9: store with backpressure, and one without
    run_store(2'd2, 1'b1, 2'd2, 1'b1, "store32x3");
    run_store(2'd0, 1'b0, 2'd1, 1'b0, "store8x2");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule